// File: doc/BRIEF.md
# Programmable LCD raster timing generator

The block produces the raster timing for a parallel LCD panel or a display serial bridge. A pixel counter and a line counter step once per enabled pixel-clock cycle and wrap at programmed maxima. Software sets these maxima to the total width minus one and the total height minus one. Counter position zero is the first cycle of the sync pulse, so the active region starts at total minus sync start on each axis.

Four strobes are produced: data enable, horizontal sync, vertical sync and an extra start pulse. Each one is the AND of a horizontal window and a vertical window, and each window is set by four coordinates. Software gets the opposite polarity by swapping the begin and end values of a window, which then wraps and gives the complement. A test-pattern mode replaces the incoming pixels with a fixed colour, which is black when the colour is zero. A one-cycle line-reset pulse marks the line counter wrapping to zero.

Registers are written through a plain write port. Address 0 is control: bit 0 is run and bit 1 is test pattern. Address 1 holds the test colour, address 2 the pixel maximum and address 3 the line maximum. Addresses 4+4*s+k hold the window coordinates. The strobe index s is 0 for data enable, 1 for horizontal sync, 2 for vertical sync and 3 for the start pulse. The coordinate index k is 0 for horizontal start, 1 for horizontal end, 2 for vertical start and 3 for vertical end.

Top module: `lcd_timing_gen`

## Requirements
- R1: With run set, each pix_en cycle advances the pixel counter, which wraps from the pixel maximum (address 2) to 0. The line counter advances on each pixel wrap and wraps from the line maximum (address 3) to 0.
- R2: A strobe is high for position (x,y) when HS <= x < HE and VS <= y <= VE, using the coordinate addresses 4+4*s+k given above. HS equal to HE gives an empty horizontal window.
- R3: When HS > HE, the horizontal window is x >= HS or x < HE. When VS > VE, the vertical window is y > VS or y < VE. Each is the complement of the window with the two values swapped back.
- R4: Writes to the maxima and the window coordinates go to pending copies. While run is set, these reach the working copies only when the last pixel of the last line advances. While run is clear, they reach the working copies on every clock.
- R5: While run is clear, both counters are held at 0 and all strobes, pix_out and line_irq are 0. After run is set, the first enabled cycle reports position (0,0).
- R6: In a cycle with pix_en low, the counters do not move and the strobes and pix_out hold their values.
- R7: The strobes and pix_out are registered. After the clock edge of an enabled cycle, they show the strobe values for the position held in that cycle and the pix_in sampled at that edge.
- R8: With control bit 1 set, pix_out takes the colour at address 1 instead of pix_in. A colour of zero gives black.
- R9: line_irq is high for exactly one clock, directly after the clock edge at which the line counter wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | PW | Write data; coordinates use the low CW bits |
| pix_in | input | PW | Incoming pixel |
| pix_out | output | PW | Outgoing pixel |
| de_o | output | 1 | Data enable strobe |
| hsync_o | output | 1 | Horizontal sync strobe |
| vsync_o | output | 1 | Vertical sync strobe |
| stv_o | output | 1 | Extra start pulse strobe |
| line_irq | output | 1 | Line-reset pulse |

## Verification
The raster is first run with pix_en held high over several whole frames, with normal windows. This separates wrong wrap points, off-by-one window edges (exclusive horizontal end, inclusive vertical end) and a misplaced line-reset pulse. A gated pix_en pattern then shows whether anything moves on disabled cycles. A second run uses swapped coordinates, which exercises the complement form of both the horizontal and the vertical window. Mid-frame writes to the pixel maximum and a window end tell shadowed loading apart from immediate loading. Stop and restart sequences check the forced-zero outputs and the restart at position (0,0), and test-pattern runs with a zero and a nonzero colour check the pixel override.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [4:0]    wr_addr,
  input  logic [PW-1:0] wr_data,
  input  logic [PW-1:0] pix_in,
  output logic [PW-1:0] pix_out,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          stv_o,
  output logic          line_irq
);
  localparam int NS = 4;
  localparam int NW = 4 * NS;

  logic          run, tpat;
  logic [PW-1:0] col;
  logic [CW-1:0] pmax_p, lmax_p, pmax, lmax, px, ln;
  logic [CW-1:0] win_p [NW];
  logic [CW-1:0] win   [NW];
  logic [NS-1:0] strb, strb_q;

  wire [3:0] widx = 4'(wr_addr - 5'd4);
  wire adv   = run & pix_en;
  wire fwrap = adv & (px == pmax) & (ln == lmax);
  wire load  = ~run | fwrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; tpat <= 1'b0; col <= '0;
      pmax_p <= '0; lmax_p <= '0;
      for (int i = 0; i < NW; i++) win_p[i] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        5'd0: begin run <= wr_data[0]; tpat <= wr_data[1]; end
        5'd1: col <= wr_data;
        5'd2: pmax_p <= wr_data[CW-1:0];
        5'd3: lmax_p <= wr_data[CW-1:0];
        default: if (wr_addr < 5'(4 + NW)) win_p[widx] <= wr_data[CW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmax <= '0; lmax <= '0;
      for (int i = 0; i < NW; i++) win[i] <= '0;
    end else if (load) begin
      pmax <= pmax_p; lmax <= lmax_p;
      for (int i = 0; i < NW; i++) win[i] <= win_p[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      px <= '0; ln <= '0;
    end else if (pix_en) begin
      if (px == pmax) begin
        px <= '0;
        ln <= (ln == lmax) ? '0 : ln + 1'b1;
      end else begin
        px <= px + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_strobe
    wire [CW-1:0] hs = win[4*s];
    wire [CW-1:0] he = win[4*s+1];
    wire [CW-1:0] vs = win[4*s+2];
    wire [CW-1:0] ve = win[4*s+3];
    wire hwin = (hs <= he) ? (px >= hs && px < he) : (px >= hs || px < he);
    wire vwin = (vs <= ve) ? (ln >= vs && ln <= ve) : (ln > vs || ln < ve);
    assign strb[s] = hwin & vwin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      strb_q <= '0; pix_out <= '0;
    end else if (pix_en) begin
      strb_q  <= strb;
      pix_out <= tpat ? col : pix_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_irq <= 1'b0;
    else        line_irq <= fwrap;
  end

  assign de_o    = strb_q[0];
  assign hsync_o = strb_q[1];
  assign vsync_o = strb_q[2];
  assign stv_o   = strb_q[3];
endmodule

module lcd_timing_gen_chk #(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          wr_en,
  input logic          run,
  input logic          tpat,
  input logic [PW-1:0] col,
  input logic [CW-1:0] px,
  input logic [CW-1:0] ln,
  input logic [CW-1:0] pmax,
  input logic [CW-1:0] lmax,
  input logic          fwrap,
  input logic [PW-1:0] pix_out,
  input logic          de_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          stv_o,
  input logic          line_irq
);
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (px <= pmax && ln <= lmax)); // R1

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fwrap) |=> ($stable(pmax) && $stable(lmax))); // R4

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!de_o && !hsync_o && !vsync_o && !stv_o && pix_out == '0)); // R5

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_en && !wr_en) |=> ($stable(de_o) && $stable(hsync_o) &&
      $stable(vsync_o) && $stable(stv_o) && $stable(pix_out))); // R6

  AST_PATTERN_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tpat && pix_en) |=> (pix_out == $past(col))); // R8

  AST_IRQ_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> (px == '0 && ln == '0)); // R9
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CW(CW), .PW(PW)) u_chk (.*);

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [23:0] pix_in = '0;
  logic [23:0] pix_out;
  logic        de_o, hsync_o, vsync_o, stv_o, line_irq;

  lcd_timing_gen u_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pix_in(pix_in),
    .pix_out(pix_out), .de_o(de_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .stv_o(stv_o), .line_irq(line_irq)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;

  int bpx = 0, bln = 0, pmx = 0, lmx = 0, pmx_p = 0, lmx_p = 0;
  int aw [16];
  int pw [16];
  bit m_run = 0, m_tp = 0;
  logic [23:0] m_col = '0;
  bit e_st [4];
  logic [23:0] e_pix = '0;
  bit e_irq = 0;

  function automatic bit win_on(int s, int x, int y);
    int hs = aw[4*s], he = aw[4*s+1], vs = aw[4*s+2], ve = aw[4*s+3];
    bit h, v;
    h = (hs <= he) ? (x >= hs && x < he) : (x >= hs || x < he);
    v = (vs <= ve) ? (y >= vs && y <= ve) : (y > vs || y < ve);
    return h && v;
  endfunction

  function automatic void load_act();
    pmx = pmx_p; lmx = lmx_p;
    for (int i = 0; i < 16; i++) aw[i] = pw[i];
  endfunction

  function automatic void model_edge(bit pe, logic [23:0] pin, bit we, int wa, int wd);
    e_irq = 0;
    if (!m_run) begin
      for (int s = 0; s < 4; s++) e_st[s] = 0;
      e_pix = '0; bpx = 0; bln = 0;
      load_act();
    end else if (pe) begin
      for (int s = 0; s < 4; s++) e_st[s] = win_on(s, bpx, bln);
      e_pix = m_tp ? m_col : pin;
      if (bpx == pmx) begin
        bpx = 0;
        if (bln == lmx) begin bln = 0; e_irq = 1; load_act(); end
        else bln++;
      end else bpx++;
    end
    if (we) begin
      case (wa)
        0: begin m_run = wd[0]; m_tp = wd[1]; end
        1: m_col = 24'(wd);
        2: pmx_p = wd;
        3: lmx_p = wd;
        default: pw[wa-4] = wd;
      endcase
    end
  endfunction

  task automatic chk1(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk1(tag, "de", int'(de_o), int'(e_st[0]));
    chk1(tag, "hsync", int'(hsync_o), int'(e_st[1]));
    chk1(tag, "vsync", int'(vsync_o), int'(e_st[2]));
    chk1(tag, "stv", int'(stv_o), int'(e_st[3]));
    chk1(tag, "pix", int'(pix_out), int'(e_pix));
    chk1(tag, "irq", int'(line_irq), int'(e_irq));
  endtask

  task automatic step(int n, bit gate, int wi, int wa, int wd, string tag);
    for (int i = 0; i < n; i++) begin
      pix_en  = gate ? (i % 3 != 2) : 1'b1;
      pix_in  = 24'(i * 40503 + 17 + bln * 977);
      wr_en   = (i == wi);
      wr_addr = 5'(wa);
      wr_data = 24'(wd);
      @(posedge clk);
      model_edge(pix_en, pix_in, wr_en, wa, wd);
      #2;
      wr_en = 1'b0;
      check_all(tag);
    end
  endtask

  task automatic wr(int a, int d, string tag);
    step(1, 0, 0, a, d, tag);
  endtask

  task automatic t_reset();
    #2;
    check_all("R5 reset");
  endtask

  task automatic t_basic();
    wr(2, 9, "R1"); wr(3, 5, "R1");
    wr(4, 3, "R2"); wr(5, 8, "R2"); wr(6, 2, "R2"); wr(7, 4, "R2");
    wr(8, 0, "R2"); wr(9, 2, "R2"); wr(10, 0, "R2"); wr(11, 5, "R2");
    wr(12, 0, "R2"); wr(13, 10, "R2"); wr(14, 0, "R2"); wr(15, 1, "R2");
    wr(16, 4, "R2"); wr(17, 6, "R2"); wr(18, 3, "R2"); wr(19, 3, "R2");
    wr(0, 1, "R5");
    step(127, 0, -1, 0, 0, "R1 R2 R7 R9 basic");
  endtask

  task automatic t_gated();
    step(100, 1, -1, 0, 0, "R6 gated");
  endtask

  task automatic t_swap();
    wr(0, 0, "R5");
    step(3, 0, -1, 0, 0, "R5 stopped");
    wr(8, 2, "R3"); wr(9, 0, "R3");
    wr(14, 1, "R3"); wr(15, 0, "R3");
    wr(0, 1, "R3");
    step(130, 1, -1, 0, 0, "R3 swapped");
  endtask

  task automatic t_shadow();
    step(20, 0, 5, 2, 7, "R4 shadow max");
    step(20, 0, 3, 5, 6, "R4 shadow window");
    step(140, 0, -1, 0, 0, "R4 after wrap");
  endtask

  task automatic t_pattern();
    wr(0, 0, "R8"); wr(1, 0, "R8"); wr(0, 3, "R8");
    step(30, 0, -1, 0, 0, "R8 black");
    wr(1, 24'h5a3c81, "R8");
    step(25, 1, -1, 0, 0, "R8 colour");
  endtask

  task automatic t_restart();
    wr(0, 0, "R5");
    step(6, 0, -1, 0, 0, "R5 held");
    wr(0, 1, "R5");
    step(30, 0, -1, 0, 0, "R5 restart");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin aw[i] = 0; pw[i] = 0; end
    for (int s = 0; s < 4; s++) e_st[s] = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_gated();
    t_swap();
    t_shadow();
    t_pattern();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule